// File: doc/BRIEF.md
# Paged Write-Only Sprite Memory Port

This block sits between a CPU bus and the sprite definition RAM. A 4 KB window at CPU addresses 0x1000 to 0x1FFF can be switched on so that it maps onto one of 32 pages of sprite RAM, which together cover 128 KB. Bit 7 of a memory-select register switches the window on or off. A page register picks which page the window shows. The page register only accepts a new value when the written byte has bit 7 set.

The window works for writes only. A CPU write inside an enabled window goes to sprite RAM and not to system RAM. A CPU read at any address, including inside the window, always goes to system RAM. When the sprite renderer is running, it has priority on the sprite RAM bus. A CPU write into the window then holds the CPU wait line high until the first cycle in which the renderer is not requesting the bus, so the stall length follows the renderer's load. When sprites are off, window writes finish in the cycle they are presented.

The CPU holds its write strobe, address and data steady while `cpu_wait` is high. The access completes in the cycle in which `cpu_wait` is low.

Top module: `sprite_window_port`

## Requirements
- R1: After reset the window is disabled and the page is 0, so a write to 0x1000–0x1FFF asserts `sys_we` and leaves `spr_we` and `cpu_wait` low.
- R2: A `msel_wr` strobe loads data bit 7 into the window enable, which takes effect from the next cycle. Writing a byte with bit 7 clear disables the window.
- R3: An enabled window write drives `spr_addr` = {page[4:0], cpu_addr[11:0]} and `spr_wdata` = `cpu_wdata` in the cycle `spr_we` is high.
- R4: A `page_wr` strobe with data bit 7 set loads data bits 4:0 as the page. With bit 7 clear, the page is unchanged.
- R5: `sys_re` follows `cpu_rd` for every address. A read never asserts `spr_we`.
- R6: With `sprites_on` low, an enabled window write completes in the same cycle (`spr_we` high, `cpu_wait` low), whatever the value of `rnd_req`.
- R7: With `sprites_on` high, a pending window write holds `cpu_wait` high and `spr_we` low while `rnd_req` is high. In the first cycle `rnd_req` is low, it asserts `spr_we` with `cpu_wait` low.
- R8: The window covers exactly 0x1000–0x1FFF. A write outside it, such as 0x0FFF or 0x2000, asserts `sys_we` and never stalls. A write inside an enabled window never asserts `sys_we`.
- R9: `spr_we` is never high in a cycle where `sprites_on` and `rnd_req` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data, also the data for register writes |
| cpu_wr | input | 1 | CPU memory write request, held while `cpu_wait` is high |
| cpu_rd | input | 1 | CPU memory read request |
| msel_wr | input | 1 | Write strobe for the memory-select register (bit 7 = window enable) |
| page_wr | input | 1 | Write strobe for the page register (loads only if bit 7 is set) |
| sprites_on | input | 1 | Sprite renderer enabled |
| rnd_req | input | 1 | Renderer requests the sprite RAM bus this cycle |
| cpu_wait | output | 1 | CPU wait: write held off by the renderer |
| sys_we | output | 1 | System RAM write enable |
| sys_re | output | 1 | System RAM read enable |
| spr_we | output | 1 | Sprite RAM write enable |
| spr_addr | output | 17 | Sprite RAM byte address |
| spr_wdata | output | 8 | Sprite RAM write data |

## Verification
Every memory-side output (`cpu_wait`, `spr_we`, `sys_we`, `sys_re`, `spr_addr`, `spr_wdata`) is due in the same cycle as the request that causes it. Register writes change decoding from the cycle after their strobe. The bench applies inputs on the falling edge and compares all outputs one nanosecond later against a behavioural model. It then updates the model's page and enable only at the following rising edge, which keeps that one-cycle register latency in step with the design. The stall tests hold one write for 0 to 4 busy renderer cycles and check, cycle by cycle, that the grant lands exactly in the first free cycle.

// File: rtl/sprw_pkg.sv
`timescale 1ns/1ps
package sprw_pkg;

  // Classification of the current CPU memory access
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_SYS_WR = 2'd1,
    ACC_SPR_WR = 2'd2
  } acc_kind_e;

  // Default geometry
  localparam int unsigned DEF_ADDR_W   = 16;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_PAGE_W   = 5;
  localparam int unsigned DEF_WIN_W    = 12;
  localparam int unsigned DEF_WIN_BASE = 1;
  localparam int unsigned DEF_LOAD_BIT = 7;

endpackage

// File: rtl/sprw_regs.sv
`timescale 1ns/1ps
module sprw_regs #(
  parameter int unsigned DATA_W   = sprw_pkg::DEF_DATA_W,
  parameter int unsigned PAGE_W   = sprw_pkg::DEF_PAGE_W,
  parameter int unsigned LOAD_BIT = sprw_pkg::DEF_LOAD_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              msel_wr,
  input  logic              page_wr,
  output logic              win_en,
  output logic [PAGE_W-1:0] page
);

  logic              en_q,   en_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              en_ce,  page_ce;

  // Clock enables written out
  always_comb begin
    en_ce   = msel_wr;
    page_ce = page_wr & wdata[LOAD_BIT];
  end

  // Next state
  always_comb begin
    en_d   = en_q;
    page_d = page_q;
    if (en_ce)   en_d   = wdata[LOAD_BIT];
    if (page_ce) page_d = wdata[PAGE_W-1:0];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      page_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (page_ce) page_q <= page_d;
    end
  end

  assign win_en = en_q;
  assign page   = page_q;

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr && !wdata[LOAD_BIT]) |=> $stable(page_q));

  // R2
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msel_wr |=> (en_q == $past(wdata[LOAD_BIT])));

endmodule

// File: rtl/sprw_decode.sv
`timescale 1ns/1ps
module sprw_decode
  import sprw_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned PAGE_W   = DEF_PAGE_W,
  parameter int unsigned WIN_W    = DEF_WIN_W,
  parameter int unsigned WIN_BASE = DEF_WIN_BASE
) (
  input  logic                    cpu_wr,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    win_en,
  input  logic [PAGE_W-1:0]       page,
  output acc_kind_e               kind,
  output logic [PAGE_W+WIN_W-1:0] spr_addr
);

  localparam int unsigned TAG_W = ADDR_W - WIN_W;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE);

  logic in_win;

  always_comb begin
    in_win = (cpu_addr[ADDR_W-1:WIN_W] == WIN_TAG);
    kind   = ACC_NONE;
    if (cpu_wr) begin
      if (win_en && in_win) kind = ACC_SPR_WR;
      else                  kind = ACC_SYS_WR;
    end
    spr_addr = {page, cpu_addr[WIN_W-1:0]};
  end

endmodule

// File: rtl/sprw_arb.sv
`timescale 1ns/1ps
module sprw_arb
  import sprw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e kind,
  input  logic      sprites_on,
  input  logic      rnd_req,
  output logic      cpu_wait,
  output logic      spr_we,
  output logic      sys_we
);

  logic bus_busy;
  logic spr_pend;

  // Renderer owns the bus whenever it asks while sprites run
  always_comb begin
    bus_busy = sprites_on & rnd_req;
    spr_pend = (kind == ACC_SPR_WR);
    cpu_wait = spr_pend & bus_busy;
    spr_we   = spr_pend & ~bus_busy;
    sys_we   = (kind == ACC_SYS_WR);
  end

  // R9
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sprites_on && rnd_req) |-> !spr_we);

  // R7
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (!spr_we && !sys_we));

  // R6
  no_stall_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sprites_on |-> !cpu_wait);

endmodule

// File: rtl/sprite_window_port.sv
`timescale 1ns/1ps
module sprite_window_port
  import sprw_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned PAGE_W      = DEF_PAGE_W,
  parameter int unsigned WIN_W       = DEF_WIN_W,
  parameter int unsigned WIN_BASE    = DEF_WIN_BASE,
  parameter int unsigned LOAD_BIT    = DEF_LOAD_BIT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic                    cpu_wr,
  input  logic                    cpu_rd,
  input  logic                    msel_wr,
  input  logic                    page_wr,
  input  logic                    sprites_on,
  input  logic                    rnd_req,
  output logic                    cpu_wait,
  output logic                    sys_we,
  output logic                    sys_re,
  output logic                    spr_we,
  output logic [PAGE_W+WIN_W-1:0] spr_addr,
  output logic [DATA_W-1:0]       spr_wdata
);

  localparam int unsigned SPR_AW = PAGE_W + WIN_W;

  // Reset: asserted asynchronously, released through a synchroniser
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  logic              win_en;
  logic [PAGE_W-1:0] page;
  acc_kind_e         kind;
  logic [SPR_AW-1:0] dec_addr;

  sprw_regs #(
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .LOAD_BIT(LOAD_BIT)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wdata  (cpu_wdata),
    .msel_wr(msel_wr),
    .page_wr(page_wr),
    .win_en (win_en),
    .page   (page)
  );

  sprw_decode #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .WIN_W   (WIN_W),
    .WIN_BASE(WIN_BASE)
  ) u_decode (
    .cpu_wr  (cpu_wr),
    .cpu_addr(cpu_addr),
    .win_en  (win_en),
    .page    (page),
    .kind    (kind),
    .spr_addr(dec_addr)
  );

  sprw_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .kind      (kind),
    .sprites_on(sprites_on),
    .rnd_req   (rnd_req),
    .cpu_wait  (cpu_wait),
    .spr_we    (spr_we),
    .sys_we    (sys_we)
  );

  // Reads always fall through to system RAM
  assign sys_re    = cpu_rd;
  assign spr_addr  = dec_addr;
  assign spr_wdata = cpu_wdata;

  // R5
  read_no_spr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_rd && !cpu_wr) |-> !spr_we);

  // R8
  win_no_sys_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    spr_we |-> !sys_we);

endmodule

// File: tb/sprite_window_port_bench.sv
`timescale 1ns/1ps
module sprite_window_port_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr, cpu_rd, msel_wr, page_wr, sprites_on, rnd_req;
  logic        cpu_wait, sys_we, sys_re, spr_we;
  logic [16:0] spr_addr;
  logic [7:0]  spr_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  bit       m_en;
  bit [4:0] m_page;

  always #2.5 clk = ~clk;  // 200 MHz

  sprite_window_port u_sprite_window_port (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .msel_wr(msel_wr), .page_wr(page_wr),
    .sprites_on(sprites_on), .rnd_req(rnd_req), .cpu_wait(cpu_wait),
    .sys_we(sys_we), .sys_re(sys_re), .spr_we(spr_we),
    .spr_addr(spr_addr), .spr_wdata(spr_wdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, compare 1 ns later, update model at rising edge
  task automatic step(input string tag, input bit wr, input bit rd,
                      input logic [15:0] a, input logic [7:0] d,
                      input bit msel, input bit pg, input bit son, input bit rq);
    bit hit, stall;
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    msel_wr = msel; page_wr = pg; sprites_on = son; rnd_req = rq;
    #1;
    hit   = m_en && (a >= 16'h1000) && (a <= 16'h1FFF) && wr;
    stall = hit && son && rq;
    chk(tag, "cpu_wait", {31'd0, cpu_wait}, {31'd0, stall});
    chk(tag, "spr_we",   {31'd0, spr_we},   {31'd0, hit && !stall});
    chk(tag, "sys_we",   {31'd0, sys_we},   {31'd0, wr && !hit});
    chk(tag, "sys_re",   {31'd0, sys_re},   {31'd0, rd});
    if (hit && !stall) begin
      chk(tag, "spr_addr",  {15'd0, spr_addr},  {15'd0, m_page, a[11:0]});
      chk(tag, "spr_wdata", {24'd0, spr_wdata}, {24'd0, d});
    end
    @(posedge clk);
    if (msel) m_en = d[7];
    if (pg && d[7]) m_page = d[4:0];
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 16'h0000, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_page = 0;
    rst_n = 0;
    cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
    msel_wr = 0; page_wr = 0; sprites_on = 0; rnd_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < 4; i++) idle("R1");

    // R1: window disabled after reset
    step("R1", 1, 0, 16'h1234, 8'h5A, 0, 0, 0, 0);
    step("R1", 1, 0, 16'h1234, 8'h5A, 0, 0, 1, 1);

    // R4: page write without bit 7 ignored, R2: enable window
    step("R4", 0, 0, 16'h0000, 8'h05, 0, 1, 0, 0);
    step("R2", 0, 0, 16'h0000, 8'h80, 1, 0, 0, 0);
    // R3: page still 0
    step("R3", 1, 0, 16'h1ABC, 8'hC3, 0, 0, 0, 0);
    // R4: page load with bit 7
    step("R4", 0, 0, 16'h0000, 8'h85, 0, 1, 0, 0);
    step("R3", 1, 0, 16'h1FFF, 8'h11, 0, 0, 0, 0);
    // R8: boundaries
    step("R8", 1, 0, 16'h0FFF, 8'h22, 0, 0, 1, 1);
    step("R8", 1, 0, 16'h2000, 8'h33, 0, 0, 1, 1);
    step("R8", 1, 0, 16'h1000, 8'h44, 0, 0, 0, 0);
    // R4: page 31
    step("R4", 0, 0, 16'h0000, 8'h9F, 0, 1, 0, 0);
    step("R3", 1, 0, 16'h1000, 8'h77, 0, 0, 0, 0);
    // R5: reads fall through
    step("R5", 0, 1, 16'h1800, 8'h00, 0, 0, 0, 0);
    step("R5", 0, 1, 16'h1800, 8'h00, 0, 0, 1, 1);
    step("R5", 0, 1, 16'h4000, 8'h00, 0, 0, 1, 0);
    // R6: sprites off, renderer busy has no effect
    step("R6", 1, 0, 16'h1555, 8'hA5, 0, 0, 0, 1);
    step("R6", 1, 0, 16'h1AAA, 8'h5A, 0, 0, 0, 1);

    // R7/R9: stalls of length 0..4
    for (int n = 0; n < 5; n++) begin
      for (int k = 0; k < n; k++)
        step("R7", 1, 0, 16'h1100 + 16'(n), 8'(8'h10 + n), 0, 0, 1, 1);
      step("R9", 1, 0, 16'h1100 + 16'(n), 8'(8'h10 + n), 0, 0, 1, 0);
      idle("R7");
    end

    // R4: no-bit-7 write keeps page 31
    step("R4", 0, 0, 16'h0000, 8'h03, 0, 1, 0, 0);
    step("R4", 1, 0, 16'h1321, 8'h99, 0, 0, 0, 0);
    // R2: disable window
    step("R2", 0, 0, 16'h0000, 8'h7F, 1, 0, 0, 0);
    step("R2", 1, 0, 16'h1321, 8'h99, 0, 0, 1, 1);
    idle("R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule